// File: doc/BRIEF.md
# Timed-Unlock Vector Select Register

This block is a small control register that sits next to a processor core. It holds a vector-select bit, which tells the interrupt logic which of two vector tables is in use, and a change-enable bit that guards it. Software cannot move the select bit with a single write. It must first write a 1 to the change-enable bit, which opens a short unlock window. It must then write the new select value, with the change-enable bit at 0, before that window closes. If no such write arrives, the change-enable bit clears itself and the window is gone.

While the sequence runs, the block drives an interrupt-block output. The interrupt controller uses this output to hold off interrupts, so that no interrupt is taken while the vector table may be changing. The global interrupt-enable flag of the core is left alone. When the select bit is committed, the blackout lasts until the instruction after the committing one has retired. For this purpose the core supplies a one-cycle retire pulse. The remaining bits of the register are ordinary read/write storage.

Top module: `tusel_ctrl_reg`

## Requirements
- R1: After reset, every register bit reads 0 (including the select bit and the change-enable bit), and irq_block is 0.
- R2: A write with the change-enable bit (bit 0) at 1, while no window is open, opens the window. Bit 0 of reg_q reads 1 from the next cycle. That write leaves the select bit (bit 1) unchanged.
- R3: A write with bit 0 at 0 in any of the WINDOW cycles after the opening write commits the window. vec_sel and reg_q bit 1 take the written bit 1 from the next cycle, and bit 0 reads 0 from the next cycle.
- R4: Without a commit, bit 0 reads 1 for exactly WINDOW cycles after the opening write and then reads 0.
- R5: A write to bit 1 while no window is open leaves vec_sel unchanged. This includes a write that arrives after the window has expired.
- R6: irq_block is 1 combinationally in the cycle of the opening write, and it stays 1 for every cycle in which the window is open.
- R7: After a commit, irq_block stays 1 until the first retire pulse that comes strictly after the commit cycle, and it reads 0 in the cycle after that pulse. A retire pulse in the commit cycle itself does not end the blackout.
- R8: If the window expires without a commit, irq_block reads 0 in the same cycle that bit 0 first reads 0.
- R9: Bits 7 to 2 are plain storage. Every write loads them from wr_data on the next cycle, whatever the state of the unlock sequence, and the sequence itself never changes them.
- R10: A write with bit 0 at 1 while the window is already open does not change vec_sel and does not restart the window, so the window still closes WINDOW cycles after the original opening write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data, with bit 1 as the select bit and bit 0 as the change-enable bit |
| retire | input | 1 | One-cycle pulse when an instruction retires |
| reg_q | output | DATA_W | Current register contents for read-back |
| vec_sel | output | 1 | Current vector-select value |
| irq_block | output | 1 | Holds off interrupt acceptance while high |

## Verification
The bench builds the block with DATA_W of 8, SEL_BIT of 1, CEN_BIT of 0 and WINDOW of 4. With these values a commit can be placed in the first and in the last cycle of the window, and a late write can be placed in the cycle just after the window expires, all in a few cycles. The plain upper six bits carry alternating patterns while the unlock sequence runs, which shows that the sequence does not disturb them. Retire pulses are placed both in the commit cycle and several cycles later, so the bench can tell whether the blackout tail ends on the first retire pulse after the commit.

// File: rtl/tusel_pkg.sv
package tusel_pkg;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_OPEN   = 2'd1,
    WK_COMMIT = 2'd2,
    WK_PLAIN  = 2'd3
  } wr_kind_e;

  // Sort one bus write by the guard bit it carries and the window state.
  function automatic wr_kind_e classify_write(logic wr, logic guard_bit, logic window_open);
    if (!wr)                       return WK_NONE;
    if (guard_bit && !window_open) return WK_OPEN;
    if (!guard_bit && window_open) return WK_COMMIT;
    return WK_PLAIN;
  endfunction

  // Width needed to count 0..limit.
  function automatic int count_width(int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/tusel_decode.sv
module tusel_decode
  import tusel_pkg::*;
(
  input  logic wr_en,
  input  logic guard_bit,
  input  logic sel_bit,
  input  logic window_open,
  output logic open_ev,
  output logic commit_ev,
  output logic sel_value
);

  wr_kind_e kind;

  always_comb begin
    kind      = classify_write(wr_en, guard_bit, window_open);
    open_ev   = (kind == WK_OPEN);
    commit_ev = (kind == WK_COMMIT);
    sel_value = sel_bit;
  end

endmodule

// File: rtl/tusel_window.sv
module tusel_window
  import tusel_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_ev,
  input  logic commit_ev,
  output logic window_open,
  output logic expire_ev
);

  localparam int CNT_W = count_width(WINDOW);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (open_ev) begin
      cnt_q <= LOAD_VAL;
    end else if (commit_ev) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_VAL;
    end
  end

  assign window_open = (cnt_q != '0);
  assign expire_ev   = (cnt_q == ONE_VAL) && !commit_ev;

endmodule

// File: rtl/tusel_tail.sv
module tusel_tail (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_ev,
  input  logic retire,
  output logic tail_q
);

  // Set by a commit; cleared by the first retire after the commit cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= 1'b0;
    end else if (commit_ev) begin
      tail_q <= 1'b1;
    end else if (tail_q && retire) begin
      tail_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tusel_store.sv
module tusel_store #(
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 1,
  parameter int CEN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_ev,
  input  logic              sel_value,
  input  logic              window_open,
  output logic [DATA_W-1:0] reg_q,
  output logic              vec_sel
);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else if (commit_ev) sel_q <= sel_value;
  end

  assign vec_sel = sel_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == SEL_BIT) begin : g_sel
      assign reg_q[i] = sel_q;
    end else if (i == CEN_BIT) begin : g_cen
      assign reg_q[i] = window_open;
    end else begin : g_plain
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else if (wr_en) bit_q <= wr_data[i];
      end
      assign reg_q[i] = bit_q;
    end
  end

endmodule

// File: rtl/tusel_ctrl_reg.sv
module tusel_ctrl_reg #(
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 1,
  parameter int CEN_BIT = 0,
  parameter int WINDOW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              retire,
  output logic [DATA_W-1:0] reg_q,
  output logic              vec_sel,
  output logic              irq_block
);

  // Internal events, named so the checker can observe them.
  logic open_ev;
  logic commit_ev;
  logic expire_ev;
  logic window_open;
  logic tail_q;
  logic sel_value;

  tusel_decode u_decode (
    .wr_en      (wr_en),
    .guard_bit  (wr_data[CEN_BIT]),
    .sel_bit    (wr_data[SEL_BIT]),
    .window_open(window_open),
    .open_ev    (open_ev),
    .commit_ev  (commit_ev),
    .sel_value  (sel_value)
  );

  tusel_window #(.WINDOW(WINDOW)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_ev    (open_ev),
    .commit_ev  (commit_ev),
    .window_open(window_open),
    .expire_ev  (expire_ev)
  );

  tusel_tail u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_ev(commit_ev),
    .retire   (retire),
    .tail_q   (tail_q)
  );

  tusel_store #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT), .CEN_BIT(CEN_BIT)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .commit_ev  (commit_ev),
    .sel_value  (sel_value),
    .window_open(window_open),
    .reg_q      (reg_q),
    .vec_sel    (vec_sel)
  );

  assign irq_block = open_ev | window_open | tail_q;

endmodule

// File: rtl/tusel_ctrl_reg_chk.sv
module tusel_ctrl_reg_chk #(
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 1,
  parameter int CEN_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              retire,
  input logic [DATA_W-1:0] reg_q,
  input logic              vec_sel,
  input logic              irq_block,
  input logic              open_ev,
  input logic              commit_ev,
  input logic              expire_ev,
  input logic              tail_q
);

  localparam logic [DATA_W-1:0] PLAIN_MASK =
    ~((DATA_W'(1) << SEL_BIT) | (DATA_W'(1) << CEN_BIT));

  AST_OPEN_SETS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    open_ev |=> reg_q[CEN_BIT]); // R2

  AST_COMMIT_LOADS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (vec_sel == $past(wr_data[SEL_BIT])) && !reg_q[CEN_BIT]); // R3

  AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> !reg_q[CEN_BIT]); // R4

  AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[CEN_BIT] && !commit_ev && !expire_ev) |=> reg_q[CEN_BIT]); // R4

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(vec_sel)); // R5

  AST_OPEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (open_ev || reg_q[CEN_BIT]) |-> irq_block); // R6

  AST_TAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q && !retire) |=> irq_block); // R7

  AST_IDLE_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_ev && !reg_q[CEN_BIT] && !tail_q) |-> !irq_block); // R8

  AST_PLAIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((reg_q & PLAIN_MASK) == ($past(wr_data) & PLAIN_MASK))); // R9

  AST_SEL_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
    vec_sel == reg_q[SEL_BIT]); // R3

endmodule

bind tusel_ctrl_reg tusel_ctrl_reg_chk #(
  .DATA_W (DATA_W),
  .SEL_BIT(SEL_BIT),
  .CEN_BIT(CEN_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .retire   (retire),
  .reg_q    (reg_q),
  .vec_sel  (vec_sel),
  .irq_block(irq_block),
  .open_ev  (open_ev),
  .commit_ev(commit_ev),
  .expire_ev(expire_ev),
  .tail_q   (tail_q)
);

// File: tb/tusel_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module tusel_ctrl_reg_tb_top;

  localparam int DATA_W = 8;
  localparam int WINDOW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              retire = 1'b0;
  logic [DATA_W-1:0] reg_q;
  logic              vec_sel;
  logic              irq_block;

  always #2 clk = ~clk;

  tusel_ctrl_reg #(.DATA_W(DATA_W), .SEL_BIT(1), .CEN_BIT(0), .WINDOW(WINDOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .retire(retire),
    .reg_q(reg_q), .vec_sel(vec_sel), .irq_block(irq_block)
  );

  typedef struct {
    string             tag;
    logic [DATA_W-1:0] reg_v;
    logic              sel_v;
    logic              blk_v;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Bench model state: plain bits, select, guard count, tail.
  logic [DATA_W-1:0] m_plain = '0;
  logic              m_sel   = 1'b0;
  int                m_cnt   = 0;
  logic              m_tail  = 1'b0;

  task automatic step(input logic wr, input logic [DATA_W-1:0] d, input logic ret, input string tag);
    exp_t e;
    logic opn, cmt;
    @(negedge clk);
    wr_en = wr; wr_data = d; retire = ret;
    opn = wr && d[0] && (m_cnt == 0);
    cmt = wr && !d[0] && (m_cnt != 0);
    e.tag   = tag;
    e.reg_v = {m_plain[DATA_W-1:2], m_sel, (m_cnt != 0)};
    e.sel_v = m_sel;
    e.blk_v = opn || (m_cnt != 0) || m_tail;
    exp_q.push_back(e);
    if (wr) m_plain = d;
    if (cmt) begin
      m_sel = d[1]; m_cnt = 0; m_tail = 1'b1;
    end else begin
      if (opn) m_cnt = WINDOW;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      if (m_tail && ret) m_tail = 1'b0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, tag);
  endtask

  // Monitor: compares each cycle's outputs one time unit after the driver.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (reg_q !== e.reg_v || vec_sel !== e.sel_v || irq_block !== e.blk_v) begin
          n_bad++;
          $display("FAIL %s: reg_q=%h vec_sel=%b irq_block=%b expected reg_q=%h vec_sel=%b irq_block=%b",
                   e.tag, reg_q, vec_sel, irq_block, e.reg_v, e.sel_v, e.blk_v);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle(2, "R1 reset state");
    rst_n = 1'b1;
    idle(2, "R1 after reset");
    // Open, commit sel=1 in first window cycle with retire in commit cycle.
    step(1'b1, 8'hA5, 1'b0, "R2 R6 open window");
    step(1'b1, 8'h5A, 1'b1, "R3 R7 commit sel with retire");
    idle(3, "R7 tail holds block");
    step(1'b0, '0, 1'b1, "R7 retire after commit");
    idle(2, "R7 block released");
    // Expire without commit, then a late write.
    step(1'b1, 8'h01, 1'b0, "R2 open keeps sel");
    idle(WINDOW, "R4 R6 window running");
    step(1'b1, 8'hC0, 1'b0, "R5 R8 late write after expiry");
    idle(2, "R5 sel unchanged");
    // Commit on the last window cycle.
    step(1'b1, 8'h3D, 1'b0, "R2 open again");
    idle(WINDOW - 1, "R6 window running");
    step(1'b1, 8'hFC, 1'b0, "R3 commit on last cycle");
    idle(1, "R3 loaded");
    step(1'b0, '0, 1'b1, "R7 retire");
    idle(2, "R7 released");
    // Re-open while open does not restart.
    step(1'b1, 8'h81, 1'b0, "R10 open");
    step(1'b1, 8'h47, 1'b0, "R10 second open write");
    idle(WINDOW + 1, "R10 window not restarted");
    // Plain writes outside any window.
    step(1'b1, 8'h02, 1'b0, "R5 sel write outside window");
    step(1'b1, 8'hAA, 1'b0, "R9 plain pattern");
    step(1'b1, 8'h54, 1'b0, "R9 plain pattern");
    idle(2, "R9 plain hold");
    // Reset again mid-sequence.
    step(1'b1, 8'hF1, 1'b0, "R2 open before reset");
    @(negedge clk);
    rst_n = 1'b0;
    m_plain = '0; m_sel = 1'b0; m_cnt = 0; m_tail = 1'b0;
    idle(1, "R1 reset mid window");
    rst_n = 1'b1;
    idle(2, "R1 post reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule